// File: doc/BRIEF.md
# Counted-Enable Interrupt Pending Aggregator

This block gathers a parameterized set of level-sensitive interrupt sources and turns them into one CPU interrupt request plus a vector answer. Each source's enable is a small counter, not a single mask bit. A separate mask-register block raises or lowers that counter with one-cycle grant and revoke pulses. The source is enabled only while its count has climbed exactly to the maximum configured for it.

A source is pending while its level input is high and it is enabled. A running tally of pending sources is kept, and the CPU request is high whenever that tally is nonzero. The vector answer picks the pending source with the smallest index. The answer is suppressed when the CPU's 4-bit interrupt mask is all ones.

All state is registered. Level, grant and revoke inputs sampled at one rising edge are reflected in the pending tally, the request and the vector right after that same edge.

Top module: `cnt_enable_irq_agg`

## Requirements
- R1: While reset is low, and right after it is released, `pend_count` is 0, `cpu_irq` is 0, `vec_valid` is 0 and `vec_out` is 0. An enable count cleared by reset starts again from 0.
- R2: Source i is pending exactly when its level sampled at the last edge is 1 and its enable count after that edge equals its field of `en_max_cfg` (bits [i*CNT_W +: CNT_W]).
- R3: A grant pulse on bit i raises the enable count of source i by one, and a revoke pulse lowers it by one. Both take effect at the sampling edge.
- R4: A grant while the count already equals the maximum is ignored. A revoke while the count is 0 is ignored.
- R5: A grant and a revoke for the same source in the same cycle leave its count unchanged.
- R6: The pending state follows the sampled level. Holding a level for several cycles does not change the tally.
- R7: `pend_count` equals the number of pending sources. This holds when several sources become pending and stop being pending in the same cycle.
- R8: `cpu_irq` is 1 exactly when `pend_count` is nonzero, with no extra cycle of delay.
- R9: With at least one source pending and `cpu_imask` not 4'hF, `vec_valid` is 1. `vec_out` carries that source's field of `vec_cfg` (bits [i*VEC_W +: VEC_W]) for the lowest-indexed pending source.
- R10: With `cpu_imask` equal to 4'hF, `vec_valid` is 0 and `vec_out` is 0. All other mask values leave the vector answer untouched.
- R11: With no source pending, `vec_valid` is 0 and `vec_out` is 0.
- R12: A source whose maximum is 0 is enabled without any grant. Grants and revokes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_in | input | N_SRC | Level of each interrupt source |
| en_grant | input | N_SRC | One-cycle enable grant pulse per source |
| en_revoke | input | N_SRC | One-cycle enable revoke pulse per source |
| en_max_cfg | input | N_SRC*CNT_W | Per-source enable maximum, static |
| vec_cfg | input | N_SRC*VEC_W | Per-source vector number, static |
| cpu_imask | input | 4 | CPU interrupt mask level |
| cpu_irq | output | 1 | CPU interrupt request |
| pend_count | output | $clog2(N_SRC+1) | Number of pending sources |
| vec_valid | output | 1 | Vector answer is valid |
| vec_out | output | VEC_W | Vector of the lowest-indexed pending source |

## Verification
Two things can happen in the same cycle: one source's pending state rises while another's falls, and a grant and a revoke can hit the same source. The stimulus table drops one source's level while another source with a zero maximum is raised. The expected result is an unchanged tally, a request that never dips, and a vector that moves to the new source. A separate table step pulses grant and revoke together on one source. The bench then confirms that the source stays pending and later drops after a single revoke.

// File: rtl/cnt_irq_agg_pkg.sv
package cnt_irq_agg_pkg;
   localparam int unsigned MAX_SOURCES = 32;
   localparam int unsigned MASK_ALL    = 15;

   typedef enum logic [1:0] {
      EN_HOLD = 2'd0,
      EN_UP   = 2'd1,
      EN_DOWN = 2'd2
   } en_step_e;
endpackage

// File: rtl/cnt_irq_src_slot.sv
module cnt_irq_src_slot
   import cnt_irq_agg_pkg::*;
#(
   parameter int unsigned CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             level,
   input  logic             grant,
   input  logic             revoke,
   input  logic [CNT_W-1:0] en_max,
   output logic             pend_q,
   output logic             pend_rise,
   output logic             pend_fall
);
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             pend_d;
   en_step_e         step;

   always_comb begin
      step = EN_HOLD;
      if (grant && !revoke && (cnt_q < en_max))
         step = EN_UP;
      else if (revoke && !grant && (cnt_q != '0))
         step = EN_DOWN;
   end

   always_comb begin
      unique case (step)
         EN_UP:   cnt_d = cnt_q + 1'b1;
         EN_DOWN: cnt_d = cnt_q - 1'b1;
         default: cnt_d = cnt_q;
      endcase
   end

   assign pend_d    = level && (cnt_d == en_max);
   assign pend_rise = pend_d && !pend_q;
   assign pend_fall = !pend_d && pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         pend_q <= pend_d;
      end
   end

   // R4: the enable count never climbs past its maximum
   assert_cnt_saturates_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= en_max);

   // R2: a pending source is fully enabled
   assert_pend_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> (cnt_q == en_max));
endmodule

// File: rtl/cnt_irq_tally.sv
module cnt_irq_tally #(
   parameter int unsigned N_SRC = 8,
   localparam int unsigned PW   = $clog2(N_SRC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] rise,
   input  logic [N_SRC-1:0] fall,
   output logic [PW-1:0]    count_q,
   output logic             irq_q
);
   logic [PW-1:0] n_up, n_dn, count_d;

   always_comb begin
      n_up = '0;
      n_dn = '0;
      for (int k = 0; k < int'(N_SRC); k++) begin
         n_up = n_up + PW'(rise[k]);
         n_dn = n_dn + PW'(fall[k]);
      end
      count_d = count_q + n_up - n_dn;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         irq_q   <= 1'b0;
      end else begin
         count_q <= count_d;
         irq_q   <= (count_d != '0);
      end
   end

   // R8: request and tally move together
   assert_irq_follows_tally_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q == (count_q != '0));

   // R7: tally never exceeds the number of sources
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= PW'(N_SRC));
endmodule

// File: rtl/cnt_irq_vec_pick.sv
module cnt_irq_vec_pick
   import cnt_irq_agg_pkg::*;
#(
   parameter int unsigned N_SRC = 8,
   parameter int unsigned VEC_W = 12
) (
   input  logic [N_SRC-1:0]       pend,
   input  logic [N_SRC*VEC_W-1:0] vec_tbl,
   input  logic [3:0]             imask,
   output logic                   valid,
   output logic [VEC_W-1:0]       vec
);
   logic             hit;
   logic [VEC_W-1:0] sel;

   always_comb begin
      hit = 1'b0;
      sel = '0;
      for (int k = int'(N_SRC) - 1; k >= 0; k--) begin
         if (pend[k]) begin
            hit = 1'b1;
            sel = vec_tbl[k*VEC_W +: VEC_W];
         end
      end
   end

   assign valid = hit && (imask != 4'(MASK_ALL));
   assign vec   = valid ? sel : '0;
endmodule

// File: rtl/cnt_enable_irq_agg.sv
module cnt_enable_irq_agg
   import cnt_irq_agg_pkg::*;
#(
   parameter int unsigned N_SRC = 8,
   parameter int unsigned VEC_W = 12,
   parameter int unsigned CNT_W = 3,
   localparam int unsigned PW   = $clog2(N_SRC + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_SRC-1:0]       lvl_in,
   input  logic [N_SRC-1:0]       en_grant,
   input  logic [N_SRC-1:0]       en_revoke,
   input  logic [N_SRC*CNT_W-1:0] en_max_cfg,
   input  logic [N_SRC*VEC_W-1:0] vec_cfg,
   input  logic [3:0]             cpu_imask,
   output logic                   cpu_irq,
   output logic [PW-1:0]          pend_count,
   output logic                   vec_valid,
   output logic [VEC_W-1:0]       vec_out
);
   if (N_SRC < 1 || N_SRC > MAX_SOURCES) begin : g_bad_nsrc
      $error("N_SRC out of range");
   end
   if (VEC_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("VEC_W and CNT_W must be positive");
   end

   logic [N_SRC-1:0] pend_vec, rise_vec, fall_vec;

   for (genvar i = 0; i < N_SRC; i++) begin : g_slot
      cnt_irq_src_slot #(.CNT_W(CNT_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .level     (lvl_in[i]),
         .grant     (en_grant[i]),
         .revoke    (en_revoke[i]),
         .en_max    (en_max_cfg[i*CNT_W +: CNT_W]),
         .pend_q    (pend_vec[i]),
         .pend_rise (rise_vec[i]),
         .pend_fall (fall_vec[i])
      );
   end

   cnt_irq_tally #(.N_SRC(N_SRC)) u_tally (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise    (rise_vec),
      .fall    (fall_vec),
      .count_q (pend_count),
      .irq_q   (cpu_irq)
   );

   cnt_irq_vec_pick #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_pick (
      .pend    (pend_vec),
      .vec_tbl (vec_cfg),
      .imask   (cpu_imask),
      .valid   (vec_valid),
      .vec     (vec_out)
   );

   // R7: tally agrees with the per-source pending flags
   assert_tally_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pend_count == PW'($countones(pend_vec)));

   // R10: an all-ones mask blocks the vector
   assert_mask_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_imask == 4'hF) |-> !vec_valid);

   // R11: an invalid vector reads as zero
   assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_valid |-> (vec_out == '0));
endmodule

// File: tb/cnt_enable_irq_agg_tb.sv
`timescale 1ns/1ps
module cnt_enable_irq_agg_tb;
   localparam int N = 8;
   localparam int VW = 12;
   localparam int CW = 3;
   localparam int PW = $clog2(N + 1);

   typedef struct packed {
      logic [7:0]  lvl;
      logic [7:0]  gnt;
      logic [7:0]  rvk;
      logic [3:0]  msk;
      logic [3:0]  ecnt;
      logic        ev;
      logic [11:0] evec;
   } step_t;

   // enable maxima: src0..7 = 2,1,0,3,1,2,0,1 ; vector i = 0x400 + 0x20*i
   localparam step_t TBL [13] = '{
      '{8'h04, 8'h00, 8'h00, 4'h0, 4'd1, 1'b1, 12'h440}, // R12 src2 max 0
      '{8'h06, 8'h02, 8'h00, 4'h0, 4'd2, 1'b1, 12'h420}, // R3 grant src1
      '{8'h07, 8'h01, 8'h02, 4'h0, 4'd1, 1'b1, 12'h440}, // R3 revoke src1
      '{8'h07, 8'h03, 8'h00, 4'h0, 4'd3, 1'b1, 12'h400}, // R9 lowest index
      '{8'h07, 8'h01, 8'h00, 4'hF, 4'd3, 1'b0, 12'h000}, // R4 R10
      '{8'h03, 8'h00, 8'h01, 4'hE, 4'd1, 1'b1, 12'h420}, // R10 mask E
      '{8'h42, 8'h02, 8'h02, 4'h3, 4'd2, 1'b1, 12'h420}, // R5 cancel
      '{8'h40, 8'h00, 8'h02, 4'h0, 4'd1, 1'b1, 12'h4C0},
      '{8'h00, 8'h00, 8'h02, 4'h0, 4'd0, 1'b0, 12'h000}, // R11 idle
      '{8'h02, 8'h00, 8'h00, 4'h0, 4'd0, 1'b0, 12'h000}, // R4 no underflow
      '{8'h02, 8'h02, 8'h00, 4'h0, 4'd1, 1'b1, 12'h420},
      '{8'h40, 8'h00, 8'h00, 4'h0, 4'd1, 1'b1, 12'h4C0}, // R7 swap
      '{8'h00, 8'h00, 8'h00, 4'h0, 4'd0, 1'b0, 12'h000}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N-1:0]      lvl = '0, gnt = '0, rvk = '0;
   logic [3:0]        msk = '0;
   logic [N*CW-1:0]   max_cfg;
   logic [N*VW-1:0]   vcfg;
   logic              irq, vvalid;
   logic [PW-1:0]     pcnt;
   logic [VW-1:0]     vout;
   int                checks = 0, errors = 0;
   bit                done = 0;

   always #2.5 clk = ~clk;

   initial begin
      int mx [8] = '{2, 1, 0, 3, 1, 2, 0, 1};
      for (int i = 0; i < N; i++) begin
         max_cfg[i*CW +: CW] = CW'(mx[i]);
         vcfg[i*VW +: VW]    = VW'(12'h400 + 12'h20 * i);
      end
   end

   cnt_enable_irq_agg #(.N_SRC(N), .VEC_W(VW), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .lvl_in(lvl), .en_grant(gnt), .en_revoke(rvk),
      .en_max_cfg(max_cfg), .vec_cfg(vcfg), .cpu_imask(msk),
      .cpu_irq(irq), .pend_count(pcnt), .vec_valid(vvalid), .vec_out(vout));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic outs(string req, int c, logic v, logic [11:0] vec);
      chk({req, " count"}, 32'(pcnt), 32'(c));
      chk("R8 irq", 32'(irq), 32'(c != 0));
      chk({req, " valid"}, 32'(vvalid), 32'(v));
      chk({req, " vector"}, 32'(vout), 32'(vec));
   endtask

   // called at a negedge; returns at the next negedge with pulses cleared
   task automatic step(logic [7:0] l, logic [7:0] g, logic [7:0] r, logic [3:0] m);
      lvl = l; gnt = g; rvk = r; msk = m;
      @(negedge clk);
      gnt = '0; rvk = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      outs("R1 in reset", 0, 1'b0, 12'h000);
      rst_n = 1'b1;
      step(8'h00, 8'h00, 8'h00, 4'h0);
      outs("R1 after reset", 0, 1'b0, 12'h000);

      for (int t = 0; t < 13; t++) begin
         step(TBL[t].lvl, TBL[t].gnt, TBL[t].rvk, TBL[t].msk);
         outs("R2 R7 R9 table", int'(TBL[t].ecnt), TBL[t].ev, TBL[t].evec);
      end

      // R6: held level keeps the tally steady
      for (int k = 0; k < 3; k++) begin
         step(8'h04, 8'h00, 8'h00, 4'h0);
         outs("R6 hold", 1, 1'b1, 12'h440);
      end
      step(8'h00, 8'h00, 8'h00, 4'h0);
      outs("R6 release", 0, 1'b0, 12'h000);

      // R4: src3 (max 3) reaches max after three grants, extra grant ignored
      step(8'h08, 8'h08, 8'h00, 4'h0);
      outs("R3 grant1", 0, 1'b0, 12'h000);
      step(8'h08, 8'h08, 8'h00, 4'h0);
      step(8'h08, 8'h08, 8'h00, 4'h0);
      outs("R2 grant3", 1, 1'b1, 12'h460);
      step(8'h08, 8'h08, 8'h00, 4'h0);
      outs("R4 extra grant", 1, 1'b1, 12'h460);
      step(8'h08, 8'h00, 8'h08, 4'h0);
      outs("R4 one revoke", 0, 1'b0, 12'h000);
      step(8'h00, 8'h00, 8'h00, 4'h0);

      // R12: src6 max 0 ignores grant and revoke
      step(8'h40, 8'h40, 8'h00, 4'h0);
      outs("R12 grant", 1, 1'b1, 12'h4C0);
      step(8'h40, 8'h00, 8'h40, 4'h0);
      outs("R12 revoke", 1, 1'b1, 12'h4C0);

      // R1: reset mid-run clears everything, counts restart from zero
      rst_n = 1'b0;
      #1;
      outs("R1 async reset", 0, 1'b0, 12'h000);
      @(negedge clk);
      rst_n = 1'b1;
      step(8'h02, 8'h00, 8'h00, 4'h0);
      outs("R1 count cleared", 0, 1'b0, 12'h000);
      step(8'h02, 8'h02, 8'h00, 4'h0);
      outs("R3 regrant", 1, 1'b1, 12'h420);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule